// File: doc/BRIEF.md
# Adaptive Bimode Table Mode Controller

This controller decides, while a workload runs, how many of the dual-purpose tagged tables in an indirect-target predictor are indexed by the branch address alone and how many by address combined with branch history. Address-only tables behave like extra target-buffer capacity for branches that always jump to one place. History-hashed tables track branches whose target depends on the path that led to them. The controller watches resolved mispredictions. A miss in the base table and in every address-only table points to a shortage of target-buffer capacity. A hit in the base table points to a need for more history-correlated tables.

The evidence feeds two identical saturating pressure counters of `CNT_W` bits. Both start at the midpoint 2^(CNT_W-1). A state machine holds the 2-bit mode and has three states. EASY (code 00) puts every table on history hashing. NORMAL (01) puts the even-indexed tables on address-only hashing. HARD (10) puts every table on address-only hashing. The ESCALATE transitions are EASY to NORMAL and NORMAL to HARD. They fire on a raise event that finds both counters already at their maximum. The RELAX transitions are HARD to NORMAL and NORMAL to EASY. They fire on a lower event that finds both counters at zero. In every other case the machine takes HOLD and keeps its state. Each transition reloads both counters to the midpoint.

The per-table select vector is decoded from the mode register. It drives the hash multiplexer of every dual-purpose table.

Top module: `pmc_top`

## Requirements
- R1: While reset is active and after it is released, the mode is EASY (code 2'b00), `hash_sel_o` is all zeros, and both pressure counters hold the midpoint 2^(CNT_W-1).
- R2: `hash_sel_o[i]`=1 selects address-only hashing for table i. In EASY (00) every bit is 0. In NORMAL (01) bits with an even index are 1 and odd bits are 0. In HARD (10) every bit is 1. Code 2'b11 decodes as HARD.
- R3: A raise event is a cycle with `mispredict_i`=1, `base_tag_hit_i`=0 and `addr_hit_i`=0. It adds one to both counters, and the counters saturate at 2^CNT_W-1. When a raise event finds both counters at the maximum, the mode steps up one level. Starting from the midpoint, the step comes on the 2^(CNT_W-1)-th consecutive raise.
- R4: A lower event is a cycle with `mispredict_i`=1 and `base_tag_hit_i`=1, whatever the value of `addr_hit_i`. It subtracts one from both counters, and the counters saturate at 0. When a lower event finds both counters at zero, the mode steps down one level. Starting from the midpoint, the step comes on the (2^(CNT_W-1)+1)-th consecutive lower.
- R5: A cycle with `mispredict_i`=0, or with `mispredict_i`=1, `base_tag_hit_i`=0 and `addr_hit_i`=1, changes neither the counters nor the mode.
- R6: Every mode step reloads both counters to the midpoint.
- R7: Raise events in HARD and lower events in EASY leave the mode unchanged, and the counters stay saturated. They do not wrap.
- R8: A mode step takes effect at the rising edge that samples the event. The outputs show the old mode until that edge.
- R9: `mode_o` never shows 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mispredict_i | input | 1 | A resolved indirect-target misprediction this cycle |
| base_tag_hit_i | input | 1 | The base table hit its partial tag for that branch |
| addr_hit_i | input | 1 | The base table or any address-only table hit its tag |
| mode_o | output | 2 | Current mode: 00 EASY, 01 NORMAL, 10 HARD |
| hash_sel_o | output | NUM_BIMODE | Per-table hash select, 1 = address-only |

## Verification
The hardest condition to reach from the ports is a step that happens at exactly the counter limit after a previous step reloaded the counters. The count of events needed depends on the hidden counter value, and that value has to be pinned down without reading internals. The bench uses a 4-bit counter configuration, so limits are reached in a few events. It drives exact-length runs of raises and lowers and inserts ignored events in between. Each step must then land on the arithmetically predicted event. Long biased pseudo-random walks follow and push the machine into both saturated ends.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    typedef enum logic [1:0] {
        MODE_EASY   = 2'b00,
        MODE_NORMAL = 2'b01,
        MODE_HARD   = 2'b10
    } pmc_mode_e;

    typedef enum logic [1:0] {
        EVT_NONE  = 2'b00,
        EVT_RAISE = 2'b01,
        EVT_LOWER = 2'b10
    } pmc_evt_e;

endpackage

// File: rtl/pmc_event_classify.sv
module pmc_event_classify
    import pmc_pkg::*;
(
    input  logic     mispredict_i,
    input  logic     base_tag_hit_i,
    input  logic     addr_hit_i,
    output pmc_evt_e evt_o
);

    always_comb begin
        evt_o = EVT_NONE;
        if (mispredict_i) begin
            if (base_tag_hit_i) begin
                evt_o = EVT_LOWER;
            end else if (!addr_hit_i) begin
                evt_o = EVT_RAISE;
            end
        end
    end

endmodule

// File: rtl/pmc_pressure_cnt.sv
module pmc_pressure_cnt
    import pmc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  pmc_evt_e         evt_i,
    input  logic             reload_i,
    output logic [CNT_W-1:0] value_o,
    output logic             at_max_o,
    output logic             at_min_o
);

    localparam logic [CNT_W-1:0] CNT_MID = {1'b1, {(CNT_W-1){1'b0}}};
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            value_o <= CNT_MID;
        end else if (reload_i) begin
            value_o <= CNT_MID;
        end else if (evt_i == EVT_RAISE && value_o != CNT_MAX) begin
            value_o <= value_o + CNT_ONE;
        end else if (evt_i == EVT_LOWER && value_o != '0) begin
            value_o <= value_o - CNT_ONE;
        end
    end

    assign at_max_o = (value_o == CNT_MAX);
    assign at_min_o = (value_o == '0);

    AST_RELOAD_MID: assert property (@(posedge clk) disable iff (!rst_n)
        reload_i |=> (value_o == CNT_MID)); // R6

    AST_NO_WRAP_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (at_max_o && evt_i == EVT_RAISE && !reload_i) |=> at_max_o); // R7

    AST_NO_WRAP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (at_min_o && evt_i == EVT_LOWER && !reload_i) |=> at_min_o); // R7

endmodule

// File: rtl/pmc_mode_fsm.sv
module pmc_mode_fsm
    import pmc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  pmc_evt_e  evt_i,
    input  logic      all_max_i,
    input  logic      all_min_i,
    output pmc_mode_e mode_o,
    output logic      reload_o
);

    pmc_mode_e state_q;
    pmc_mode_e state_d;
    logic      escalate;
    logic      relax;

    assign escalate = (evt_i == EVT_RAISE) && all_max_i;
    assign relax    = (evt_i == EVT_LOWER) && all_min_i;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_EASY: begin
                if (escalate) state_d = MODE_NORMAL;
            end
            MODE_NORMAL: begin
                if (escalate)   state_d = MODE_HARD;
                else if (relax) state_d = MODE_EASY;
            end
            MODE_HARD: begin
                if (relax) state_d = MODE_NORMAL;
            end
            default: begin
                state_d = relax ? MODE_NORMAL : MODE_HARD;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MODE_EASY;
        else        state_q <= state_d;
    end

    always_comb begin
        mode_o   = state_q;
        reload_o = (state_d != state_q);
    end

    AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != 2'b11); // R9

    AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !((state_q == MODE_HARD && $past(state_q) == MODE_EASY) ||
          (state_q == MODE_EASY && $past(state_q) == MODE_HARD))); // R3

endmodule

// File: rtl/pmc_hash_decode.sv
module pmc_hash_decode #(
    parameter int NUM_BIMODE = 9
) (
    input  logic [1:0]            mode_i,
    output logic [NUM_BIMODE-1:0] sel_o
);

    logic all_addr;
    logic half_addr;

    assign all_addr  = mode_i[1];
    assign half_addr = (mode_i == 2'b01);

    for (genvar g = 0; g < NUM_BIMODE; g++) begin : g_sel
        if (g % 2 == 0) begin : g_even
            assign sel_o[g] = all_addr | half_addr;
        end else begin : g_odd
            assign sel_o[g] = all_addr;
        end
    end

endmodule

// File: rtl/pmc_top.sv
module pmc_top
    import pmc_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int NUM_BIMODE = 9
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  mispredict_i,
    input  logic                  base_tag_hit_i,
    input  logic                  addr_hit_i,
    output logic [1:0]            mode_o,
    output logic [NUM_BIMODE-1:0] hash_sel_o
);

    localparam int NUM_CNT  = 2;
    localparam int HALF_SEL = (NUM_BIMODE + 1) / 2;

    pmc_evt_e               evt;
    pmc_mode_e              mode;
    logic                   reload;
    logic [NUM_CNT-1:0]     cnt_max;
    logic [NUM_CNT-1:0]     cnt_min;
    logic [CNT_W-1:0]       cnt_val [NUM_CNT];

    pmc_event_classify i_classify (
        .mispredict_i   (mispredict_i),
        .base_tag_hit_i (base_tag_hit_i),
        .addr_hit_i     (addr_hit_i),
        .evt_o          (evt)
    );

    for (genvar c = 0; c < NUM_CNT; c++) begin : g_cnt
        pmc_pressure_cnt #(.CNT_W(CNT_W)) i_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .evt_i    (evt),
            .reload_i (reload),
            .value_o  (cnt_val[c]),
            .at_max_o (cnt_max[c]),
            .at_min_o (cnt_min[c])
        );
    end

    pmc_mode_fsm i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_i     (evt),
        .all_max_i (&cnt_max),
        .all_min_i (&cnt_min),
        .mode_o    (mode),
        .reload_o  (reload)
    );

    assign mode_o = mode;

    pmc_hash_decode #(.NUM_BIMODE(NUM_BIMODE)) i_decode (
        .mode_i (mode),
        .sel_o  (hash_sel_o)
    );

    AST_CNT_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_val[0] == cnt_val[1]); // R3

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !mispredict_i |=> $stable(mode_o)); // R5

    AST_ADDR_HIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (mispredict_i && !base_tag_hit_i && addr_hit_i) |=> $stable(mode_o)); // R5

    AST_NORMAL_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'b01) |-> ($countones(hash_sel_o) == HALF_SEL)); // R2

    AST_EASY_NONE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'b00) |-> ($countones(hash_sel_o) == 0)); // R2

endmodule

// File: tb/test_pmc_top.sv
module test_pmc_top;

    localparam int CW  = 4;
    localparam int NB  = 5;
    localparam int MID = 1 << (CW - 1);
    localparam int MAX = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mis = 1'b0;
    logic          bh = 1'b0;
    logic          ah = 1'b0;
    logic [1:0]    mode_o;
    logic [NB-1:0] sel_o;

    int  checks = 0;
    int  failures = 0;
    int  exp_mode = 0;
    int  exp_cnt = MID;
    bit  done = 1'b0;

    always #2 clk = ~clk;

    pmc_top #(.CNT_W(CW), .NUM_BIMODE(NB)) i_pmc_top (
        .clk            (clk),
        .rst_n          (rst_n),
        .mispredict_i   (mis),
        .base_tag_hit_i (bh),
        .addr_hit_i     (ah),
        .mode_o         (mode_o),
        .hash_sel_o     (sel_o)
    );

    function automatic logic [NB-1:0] exp_sel(input int m);
        logic [NB-1:0] v = '0;
        for (int i = 0; i < NB; i++) begin
            if (m == 2) v[i] = 1'b1;
            else if (m == 1 && (i % 2) == 0) v[i] = 1'b1;
        end
        return v;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model(input logic m, input logic b, input logic a);
        if (m && b) begin
            if (exp_cnt == 0) begin
                if (exp_mode > 0) begin exp_mode--; exp_cnt = MID; end
            end else exp_cnt--;
        end else if (m && !a) begin
            if (exp_cnt == MAX) begin
                if (exp_mode < 2) begin exp_mode++; exp_cnt = MID; end
            end else exp_cnt++;
        end
    endtask

    task automatic step(input logic m, input logic b, input logic a, input string req);
        mis = m; bh = b; ah = a;
        #1;
        chk(int'(mode_o) == exp_mode, "R8", int'(mode_o), exp_mode);
        @(posedge clk);
        model(m, b, a);
        @(negedge clk);
        chk(int'(mode_o) == exp_mode, req, int'(mode_o), exp_mode);
        chk(sel_o == exp_sel(exp_mode), "R2", int'(sel_o), int'(exp_sel(exp_mode)));
        chk(mode_o != 2'b11, "R9", int'(mode_o), 0);
    endtask

    task automatic raises(input int n, input string req);
        for (int i = 0; i < n; i++) step(1'b1, 1'b0, 1'b0, req);
    endtask

    task automatic lowers(input int n, input logic a, input string req);
        for (int i = 0; i < n; i++) step(1'b1, 1'b1, a, req);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        repeat (3) @(negedge clk);
        chk(mode_o == 2'b00, "R1", int'(mode_o), 0);
        chk(sel_o == '0, "R1", int'(sel_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(mode_o == 2'b00, "R1", int'(mode_o), 0);

        // R3: midpoint to max takes MID-1 raises, the next one escalates
        raises(MID - 1, "R3");
        chk(mode_o == 2'b00, "R3", int'(mode_o), 0);
        raises(1, "R3");
        chk(mode_o == 2'b01, "R3", int'(mode_o), 1);
        chk(sel_o == 5'b10101, "R2", int'(sel_o), 21);

        // R5: ignored events must leave the counters at the midpoint
        for (int i = 0; i < 16; i++) begin
            step(1'b0, i[0], i[1], "R5");
            step(1'b1, 1'b0, 1'b1, "R5");
        end
        // R6: reload to midpoint means exactly MID raises to the next step
        raises(MID - 1, "R6");
        chk(mode_o == 2'b01, "R6", int'(mode_o), 1);
        raises(1, "R6");
        chk(mode_o == 2'b10, "R6", int'(mode_o), 2);
        chk(sel_o == 5'b11111, "R2", int'(sel_o), 31);

        // R7: further raises in HARD keep the mode, counter saturates at MAX
        raises(20, "R7");
        chk(mode_o == 2'b10, "R7", int'(mode_o), 2);

        // R4: from MAX, MAX lowers reach zero, the next one relaxes; addr flag irrelevant
        lowers(MAX, 1'b0, "R4");
        chk(mode_o == 2'b10, "R4", int'(mode_o), 2);
        lowers(1, 1'b0, "R4");
        chk(mode_o == 2'b01, "R4", int'(mode_o), 1);
        lowers(MID, 1'b1, "R4");
        chk(mode_o == 2'b01, "R4", int'(mode_o), 1);
        lowers(1, 1'b1, "R4");
        chk(mode_o == 2'b00, "R4", int'(mode_o), 0);

        // R7: lowers in EASY stay in EASY and do not wrap to MAX
        lowers(20, 1'b0, "R7");
        chk(mode_o == 2'b00, "R7", int'(mode_o), 0);
        raises(MAX, "R7");
        chk(mode_o == 2'b00, "R7", int'(mode_o), 0);
        raises(1, "R7");
        chk(mode_o == 2'b01, "R7", int'(mode_o), 1);

        // Biased random walks covering every event kind, checked against the model
        lfsr = 16'hACE1;
        for (int ph = 0; ph < 4; ph++) begin
            for (int i = 0; i < 1500; i++) begin
                logic up;
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                up = (ph % 2 == 0) ? (lfsr[4:2] < 3'd5) : (lfsr[4:2] < 3'd3);
                if (lfsr[1:0] == 2'b00) step(1'b0, lfsr[5], lfsr[6], "R5");
                else if (lfsr[7] && lfsr[8]) step(1'b1, 1'b0, 1'b1, "R5");
                else if (up) step(1'b1, 1'b0, 1'b0, "R3");
                else step(1'b1, 1'b1, lfsr[9], "R4");
            end
        end

        mis = 1'b0; bh = 1'b0; ah = 1'b0;
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule